// File: doc/BRIEF.md
# Armable Start Pattern Detector

This block hunts for a programmable start pattern in a serial receive stream. Each bit arrives on `bit_in` together with a one-cycle strobe on `bit_en`. The block slides the most recent bits through a window register and compares them with the start pattern held in `pattern`. The length of the pattern is chosen by `len_sel`. A normal frame is a preamble, then the start pattern, then the payload. Once the pattern is found, the block raises a detect pulse that lasts one bit period and sets a sticky flag. From then on it forwards only the payload bits.

After a match the detector locks itself out, so a repeat of the pattern inside the payload cannot fire it again. The host re-arms it by pulsing `clr_det`. This clears the flag, empties the window and restarts the hunt, and the host may do it at any point, including in the middle of a payload. `det_pulse` is a separate output so that an interrupt mapping stage can route it to an external interrupt pin.

Top module: `sync_hunt`

## Requirements
- R1: Only a cycle with `bit_en` high shifts a bit into the window or completes a match. While the detector is armed, the newest bit enters at the low end of the window, and earlier bits move towards the high end.
- R2: When a strobe completes a match, `det_pulse` is high from the next cycle onward. It stays high through every cycle up to and including the cycle of the next strobe, and is low after that strobe. The pulse therefore lasts exactly one bit period.
- R3: A match sets `det_flag`, which stays set until it is cleared. `det_pulse` is never high while `det_flag` is low.
- R4: While `det_flag` is set, strobed bits are not compared, and no further detect pulse occurs, even when the pattern is received again.
- R5: A one-cycle pulse on `clr_det` does the following:
  - It makes `det_flag`, `det_pulse` and `pay_valid` low in the next cycle.
  - It sets the window to all zeros and the count of bits received since arming to zero.
  - It re-arms the detector.
  - A bit strobed in the same cycle as the clear is discarded.
  - It takes effect in any state, including during a payload.
- R6: Each strobe while `det_flag` is set (without a clear) gives `pay_valid` high for exactly one cycle, in the cycle after the strobe, with `pay_bit` equal to the strobed bit. Preamble bits and pattern bits are never forwarded.
- R7: `len_sel` selects a pattern length L. The encodings are 0 for 8 bits, 1 for 16, 2 for 24 and 3 for 32. Only `pattern[L-1:0]` takes part in the compare. Bit L-1 is the first bit received and bit 0 is the last.
- R8: No match can occur until at least L bits have been strobed since arming. This holds even when the all-zero reset window equals the pattern.
- R9: After reset, `det_pulse`, `det_flag` and `pay_valid` are low, and the detector is armed with an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received data bit, sampled when `bit_en` is high |
| len_sel | input | SEL_W | Pattern length select: 0 for 8, 1 for 16, 2 for 24, 3 for 32 bits |
| pattern | input | MAX_W | Start pattern, right-aligned; bit L-1 is received first |
| clr_det | input | 1 | Host pulse that clears the flag and re-arms the detector |
| det_pulse | output | 1 | Detect pulse of one bit period, intended for interrupt routing |
| det_flag | output | 1 | Sticky start-detected status |
| pay_valid | output | 1 | One-cycle marker for a forwarded payload bit |
| pay_bit | output | 1 | Forwarded payload bit |

## Verification
The assertions check the following on every cycle:
- the pulse never appears without the flag;
- the flag only rises on a strobe and stays up until a clear;
- the pulse holds between strobes and drops after the next strobe;
- a clear empties every output;
- payload is only forwarded while locked.

Only the bench's scenarios can show that the match happens on the correct bit. They compare against an arithmetic model of the window for every length setting and several patterns. The same scenarios show that the count since arming blocks early matches against the zero window, that a repeated pattern inside the payload is ignored, and that a bit strobed together with a clear is discarded.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  // Number of bits compared for length option idx.
  function automatic int len_of(input int idx, input int step);
    return (idx + 1) * step;
  endfunction

endpackage

// File: rtl/sync_hunt_window.sv
// Shift window plus a saturating count of bits received since arming.
// The next-state values are exported so that the compare sees the bit
// that is being strobed in this cycle.
module sync_hunt_window #(
  parameter int MAX_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             restart,
  input  logic             bit_in,
  output logic [MAX_W-1:0] win_d,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_W);

  logic [MAX_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (restart) begin
      win_d = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      win_d = {win_q[MAX_W-2:0], bit_in};
      if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sync_hunt_match.sv
// One comparator per selectable length, then a select by len_sel.
module sync_hunt_match #(
  parameter int LEN_STEP = 8,
  parameter int NUM_LEN  = 4,
  parameter int MAX_W    = 32,
  parameter int SEL_W    = 2,
  parameter int CNT_W    = 6
) (
  input  logic [MAX_W-1:0] win,
  input  logic [CNT_W-1:0] cnt,
  input  logic [MAX_W-1:0] pattern,
  input  logic [SEL_W-1:0] len_sel,
  output logic             hit
);

  logic [NUM_LEN-1:0] opt_hit;

  for (genvar i = 0; i < NUM_LEN; i++) begin : g_opt
    localparam int OPT_W = sync_hunt_pkg::len_of(i, LEN_STEP);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(OPT_W);
    assign opt_hit[i] = (win[OPT_W-1:0] == pattern[OPT_W-1:0]) && (cnt >= NEED);
  end

  assign hit = opt_hit[len_sel];

endmodule

// File: rtl/sync_hunt_ctrl.sv
// Sticky flag, bit-period detect pulse and payload forwarding.
module sync_hunt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic clr,
  input  logic hit,
  output logic armed,
  output logic flag,
  output logic det,
  output logic pv,
  output logic pb
);

  logic flag_q, flag_d;
  logic det_q,  det_d;
  logic pv_q,   pv_d;
  logic pb_q,   pb_d;

  always_comb begin
    flag_d = flag_q;
    det_d  = det_q;
    if (clr) begin
      flag_d = 1'b0;
      det_d  = 1'b0;
    end else if (hit) begin
      flag_d = 1'b1;
      det_d  = 1'b1;
    end else if (bit_en) begin
      det_d  = 1'b0;
    end
    pv_d = bit_en && flag_q && !clr;
    pb_d = pv_d ? bit_in : pb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      det_q  <= 1'b0;
      pv_q   <= 1'b0;
      pb_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      det_q  <= det_d;
      pv_q   <= pv_d;
      pb_q   <= pb_d;
    end
  end

  assign armed = !flag_q;
  assign flag  = flag_q;
  assign det   = det_q;
  assign pv    = pv_q;
  assign pb    = pb_q;

endmodule

// File: rtl/sync_hunt.sv
module sync_hunt #(
  parameter int LEN_STEP = 8,
  parameter int NUM_LEN  = 4,
  localparam int MAX_W   = LEN_STEP * NUM_LEN,
  localparam int SEL_W   = (NUM_LEN > 1) ? $clog2(NUM_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] len_sel,
  input  logic [MAX_W-1:0] pattern,
  input  logic             clr_det,
  output logic             det_pulse,
  output logic             det_flag,
  output logic             pay_valid,
  output logic             pay_bit
);

  localparam int CNT_W = $clog2(MAX_W + 1);

  logic             armed;
  logic             shift_en;
  logic             match;
  logic             hit;
  logic [MAX_W-1:0] win_d;
  logic [CNT_W-1:0] cnt_d;

  // The window only moves while hunting; a clear overrides a strobe.
  assign shift_en = bit_en && armed && !clr_det;
  assign hit      = shift_en && match;

  sync_hunt_window #(
    .MAX_W (MAX_W),
    .CNT_W (CNT_W)
  ) i_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .restart  (clr_det),
    .bit_in   (bit_in),
    .win_d    (win_d),
    .cnt_d    (cnt_d)
  );

  sync_hunt_match #(
    .LEN_STEP (LEN_STEP),
    .NUM_LEN  (NUM_LEN),
    .MAX_W    (MAX_W),
    .SEL_W    (SEL_W),
    .CNT_W    (CNT_W)
  ) i_match (
    .win     (win_d),
    .cnt     (cnt_d),
    .pattern (pattern),
    .len_sel (len_sel),
    .hit     (match)
  );

  sync_hunt_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .clr    (clr_det),
    .hit    (hit),
    .armed  (armed),
    .flag   (det_flag),
    .det    (det_pulse),
    .pv     (pay_valid),
    .pb     (pay_bit)
  );

endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic clr_det,
  input logic det_pulse,
  input logic det_flag,
  input logic pay_valid
);

  p_flag_rise_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !det_flag && !bit_en |=> !det_flag);

  p_pulse_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse && !bit_en && !clr_det |=> det_pulse);

  p_pulse_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse && bit_en |=> !det_pulse);

  p_pulse_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> det_flag);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_flag && !clr_det |=> det_flag);

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_det |=> !det_flag && !det_pulse && !pay_valid);

  p_payload_when_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> det_flag);

  p_payload_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !pay_valid);

endmodule

bind sync_hunt sync_hunt_chk i_sync_hunt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .clr_det   (clr_det),
  .det_pulse (det_pulse),
  .det_flag  (det_flag),
  .pay_valid (pay_valid)
);

// File: tb/test_sync_hunt.sv
module test_sync_hunt;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        bit_in;
  logic [1:0]  len_sel;
  logic [31:0] pattern;
  logic        clr_det;
  logic        det_pulse, det_flag, pay_valid, pay_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of the requirements
  logic [31:0] m_win;
  int          m_cnt;
  int          m_len;
  bit          m_flag;

  always #5 clk = ~clk;

  sync_hunt i_sync_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .len_sel   (len_sel),
    .pattern   (pattern),
    .clr_det   (clr_det),
    .det_pulse (det_pulse),
    .det_flag  (det_flag),
    .pay_valid (pay_valid),
    .pay_bit   (pay_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mask_of(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic void model_clear();
    m_win  = '0;
    m_cnt  = 0;
    m_flag = 1'b0;
  endfunction

  // Send one strobed bit, check the cycle after it and one idle cycle later.
  task automatic send(input logic b);
    bit exp_det;
    bit exp_pv;
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    exp_det = 1'b0;
    exp_pv  = 1'b0;
    if (!m_flag) begin
      m_win = {m_win[30:0], b};
      if (m_cnt < 32) m_cnt++;
      if (m_cnt >= m_len && ((m_win ^ pattern) & mask_of(m_len)) == 32'h0) begin
        m_flag  = 1'b1;
        exp_det = 1'b1;
      end
      chk(exp_det ? "R2 pulse after matching bit" : "R1 no match on this bit",
          32'(det_pulse), 32'(exp_det));
    end else begin
      exp_pv = 1'b1;
      chk("R4 no pulse while locked", 32'(det_pulse), 32'h0);
    end
    chk("R3 sticky flag", 32'(det_flag), 32'(m_flag));
    chk("R6 payload valid", 32'(pay_valid), 32'(exp_pv));
    if (exp_pv) chk("R6 payload bit", 32'(pay_bit), 32'(b));
    @(negedge clk);
    chk("R2 pulse held between strobes", 32'(det_pulse), 32'(exp_det));
    chk("R6 payload valid one cycle", 32'(pay_valid), 32'h0);
  endtask

  task automatic clear(input bit with_bit, input logic b);
    @(negedge clk);
    clr_det = 1'b1;
    bit_en  = with_bit;
    bit_in  = b;
    @(negedge clk);
    clr_det = 1'b0;
    bit_en  = 1'b0;
    model_clear();
    chk("R5 flag cleared", 32'(det_flag), 32'h0);
    chk("R5 pulse cleared", 32'(det_pulse), 32'h0);
    chk("R5 payload cleared", 32'(pay_valid), 32'h0);
  endtask

  task automatic send_pattern();
    for (int i = m_len - 1; i >= 0; i--) send(pattern[i]);
  endtask

  task automatic frame(input int sel, input logic [31:0] pat, input logic [7:0] pay);
    len_sel = 2'(sel);
    pattern = pat;
    m_len   = (sel + 1) * 8;
    clear(1'b0, 1'b0);
    for (int i = 0; i < 24; i++) send(logic'(i % 2 == 0));
    send_pattern();
    chk("R7 detected with selected length", 32'(det_flag), 32'h1);
    for (int i = 7; i >= 0; i--) send(pay[i]);
    send_pattern();
    chk("R4 repeat pattern ignored", 32'(det_flag), 32'h1);
  endtask

  initial begin
    rst_n   = 1'b0;
    bit_en  = 1'b0;
    bit_in  = 1'b0;
    clr_det = 1'b0;
    len_sel = 2'd0;
    pattern = 32'h0;
    m_len   = 8;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R9 reset pulse", 32'(det_pulse), 32'h0);
    chk("R9 reset flag", 32'(det_flag), 32'h0);
    chk("R9 reset payload", 32'(pay_valid), 32'h0);
    rst_n = 1'b1;

    // R8: zero pattern against the zero window needs L bits since arming
    @(negedge clk);
    for (int i = 0; i < 7; i++) send(1'b0);
    chk("R8 no match before 8 bits", 32'(det_flag), 32'h0);
    send(1'b0);
    chk("R8 match on 8th bit", 32'(det_flag), 32'h1);

    // R7 sweep: every length, several patterns
    for (int sel = 0; sel < 4; sel++) begin
      for (int k = 0; k < 4; k++) begin
        frame(sel, 32'hC3A5_96E1 ^ (32'(k) * 32'h1F2E_3D4B), 8'(8'h5C + k * 37));
      end
    end

    // R5: re-arm in the middle of a payload, then find the pattern again
    len_sel = 2'd1;
    pattern = 32'h0000_B29D;
    m_len   = 16;
    clear(1'b0, 1'b0);
    send_pattern();
    for (int i = 0; i < 4; i++) send(logic'(i[0]));
    clear(1'b0, 1'b0);
    send_pattern();
    chk("R5 re-detect after mid-payload clear", 32'(det_flag), 32'h1);

    // R5: a bit strobed with the clear is discarded
    len_sel = 2'd0;
    pattern = 32'h0000_00B3;
    m_len   = 8;
    clear(1'b1, 1'b1);
    for (int i = 6; i >= 0; i--) send(pattern[i]);
    chk("R5 bit with clear discarded", 32'(det_flag), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule